// File: doc/BRIEF.md
# Linked-List DMA Channel

A single DMA channel that copies a chain of memory buffers. Each buffer is described by a five-word descriptor held in memory. Software programs an initial source address and a pointer to the first descriptor, sets the global enable, and then starts the channel. The channel reads the descriptor and copies the buffer one word at a time, with one read followed by one write. It then stores an updated control word back into the same descriptor and either follows the next pointer or ends the chain.

Every buffer in the chain starts from the same source address, which is reloaded from the programmed register. The destination comes from the descriptor that was just fetched. The source word inside each descriptor is read but never used. Software can find out that a buffer is finished in three ways: by polling the DONE bit that the channel writes into the descriptor, by taking the interrupt flags, or by polling the channel's active bit.

All addresses are word addresses. A single memory-master port carries descriptor fetches, data reads, data writes and write-backs.

Top module: `ll_dma_channel`

## Requirements
- R1: Writing 1 to bit 0 of the channel register (address 1) starts the channel only while bit 0 of the global register (address 0) is 1. Otherwise no memory request is made and the active bit stays 0.
- R2: A descriptor at pointer P is fetched as five reads, at P, P+1, P+2, P+3 and P+4, in that order. The words are: source (unused), destination, next pointer, control word A, control word B.
- R3: The data reads of every buffer begin at the value in the source register (address 2). The source word in the descriptor has no effect.
- R4: The data writes of a buffer begin at the destination word of that buffer's descriptor. Each write carries the word returned by the read just before it.
- R5: Each beat is one read at source+k followed by one write at destination+k. The beat count is bits 15:0 of control word A.
- R6: After the last beat of a buffer, the only descriptor word written back is control word A, at address P+3. In that word, bit 31 (DONE) is 1, bits 15:0 are 0, and bits 30:16 keep their fetched values.
- R7: After a write-back, if the chain continues, the buffer-complete flag (irq_buf, status bit 0) is set and the next descriptor is fetched from the next pointer.
- R8: A descriptor is the last one if its next pointer is 0 or if bit 0 of its control word B is 1. After its write-back, the chain-complete flag (irq_xfer, status bit 1) is set and the active bit (read at address 1, bit 0) returns to 0.
- R9: Reading the status register (address 4) returns the chain-complete flag in bit 1 and the buffer-complete flag in bit 0, and clears both flags.
- R10: Writing 0 to the channel bit while the channel is active stops it once the current memory access or beat is finished. No write-back is made and neither flag is set.
- R11: A memory request keeps its address, write flag and write data unchanged until the cycle in which m_ready is high. Read data is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| irq_buf | output | 1 | Buffer-complete flag |
| irq_xfer | output | 1 | Chain-complete flag |
| m_req | output | 1 | Memory request |
| m_we | output | 1 | Memory request is a write |
| m_addr | output | 32 | Memory word address |
| m_wdata | output | 32 | Memory write data |
| m_rdata | input | 32 | Memory read data, valid with m_ready |
| m_ready | input | 1 | One-cycle completion of the current request |

## Verification
Every memory access is compared with the reference model at the exact rising edge where m_ready accepts it. The first descriptor fetch appears one cycle after the enable write is accepted. A buffer's read starts two edges after the last descriptor word is accepted, because one edge is spent loading the addresses. Register reads are sampled on the falling edge after the read strobe, since reg_rdata is registered. The interrupt flags become visible two edges after the write-back is accepted, so the bench polls them on falling edges and does not sample at a fixed cycle. The memory model in the bench inserts 0 to 2 wait cycles per access, so it checks that each request is held.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOAD, ST_RD, ST_WR, ST_WB
  } eng_state_t;

  localparam logic [2:0] RA_GCTL = 3'd0;
  localparam logic [2:0] RA_CHAN = 3'd1;
  localparam logic [2:0] RA_SRC  = 3'd2;
  localparam logic [2:0] RA_DPTR = 3'd3;
  localparam logic [2:0] RA_IRQ  = 3'd4;

  localparam int DESC_WORDS = 5;
  localparam int OFS_DST    = 1;
  localparam int OFS_NEXT   = 2;
  localparam int OFS_CTLA   = 3;
  localparam int OFS_CTLB   = 4;
  localparam int LAST_BIT   = 0;
endpackage

// File: rtl/lldma_regs.sv
module lldma_regs
  import lldma_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         active,
  input  logic         evt_buf,
  input  logic         evt_xfer,
  output logic         glb_en,
  output logic         start,
  output logic         stop,
  output logic [W-1:0] src_init,
  output logic [W-1:0] desc_ptr,
  output logic         irq_buf,
  output logic         irq_xfer
);
  // Channel bit decode: start only when globally enabled and idle
  always_comb begin
    start = reg_wr && (reg_addr == RA_CHAN) && reg_wdata[0] && glb_en && !active;
    stop  = reg_wr && (reg_addr == RA_CHAN) && !reg_wdata[0] && active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en    <= 1'b0;
      src_init  <= '0;
      desc_ptr  <= '0;
      reg_rdata <= '0;
      irq_buf   <= 1'b0;
      irq_xfer  <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_GCTL: glb_en   <= reg_wdata[0];
          RA_SRC:  src_init <= reg_wdata;
          RA_DPTR: desc_ptr <= reg_wdata;
          default: ;
        endcase
      end
      if (reg_rd) begin
        case (reg_addr)
          RA_GCTL: reg_rdata <= {{(W-1){1'b0}}, glb_en};
          RA_CHAN: reg_rdata <= {{(W-1){1'b0}}, active};
          RA_SRC:  reg_rdata <= src_init;
          RA_DPTR: reg_rdata <= desc_ptr;
          RA_IRQ:  reg_rdata <= {{(W-2){1'b0}}, irq_xfer, irq_buf};
          default: reg_rdata <= '0;
        endcase
        if (reg_addr == RA_IRQ) begin
          irq_buf  <= 1'b0;
          irq_xfer <= 1'b0;
        end
      end
      // New events take priority over a read clear in the same cycle
      if (evt_buf)  irq_buf  <= 1'b1;
      if (evt_xfer) irq_xfer <= 1'b1;
    end
  end

  assert_rd_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == RA_IRQ && !evt_buf && !evt_xfer) |=> (!irq_buf && !irq_xfer));
endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
  import lldma_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         stop,
  input  logic [W-1:0] src_init,
  input  logic [W-1:0] desc_ptr,
  output logic         active,
  output logic         evt_buf,
  output logic         evt_xfer,
  output logic         m_req,
  output logic         m_we,
  output logic [W-1:0] m_addr,
  output logic [W-1:0] m_wdata,
  input  logic [W-1:0] m_rdata,
  input  logic         m_ready
);
  localparam logic [2:0] LAST_IDX = 3'(DESC_WORDS - 1);

  eng_state_t   state;
  logic [2:0]   idx;
  logic [W-1:0] ptr_cur, src_cur, dst_cur, dst_d, nxt_d, dbuf;
  logic [W-2:0] ctla;
  logic         ctlb_last, stop_pend;
  logic [CW-1:0] cnt;
  logic         stop_now, last_item;
  logic [W-1:0] wb_word;

  assign active    = (state != ST_IDLE);
  assign stop_now  = stop_pend || stop;
  assign last_item = (nxt_d == '0) || ctlb_last;
  assign wb_word   = {1'b1, ctla[W-2:CW], cnt};

  // Request fields decoded from registered state only
  always_comb begin
    m_req   = 1'b0;
    m_we    = 1'b0;
    m_addr  = ptr_cur + W'(idx);
    m_wdata = '0;
    case (state)
      ST_FETCH: m_req = 1'b1;
      ST_RD: begin
        m_req  = 1'b1;
        m_addr = src_cur;
      end
      ST_WR: begin
        m_req   = 1'b1;
        m_we    = 1'b1;
        m_addr  = dst_cur;
        m_wdata = dbuf;
      end
      ST_WB: begin
        m_req   = 1'b1;
        m_we    = 1'b1;
        m_addr  = ptr_cur + W'(OFS_CTLA);
        m_wdata = wb_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx <= '0;
      ptr_cur <= '0; src_cur <= '0; dst_cur <= '0;
      dst_d <= '0; nxt_d <= '0; dbuf <= '0; ctla <= '0;
      ctlb_last <= 1'b0; stop_pend <= 1'b0; cnt <= '0;
      evt_buf <= 1'b0; evt_xfer <= 1'b0;
    end else begin
      evt_buf  <= 1'b0;
      evt_xfer <= 1'b0;
      if (stop && state != ST_IDLE) stop_pend <= 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          ptr_cur   <= desc_ptr;
          idx       <= '0;
          stop_pend <= 1'b0;
          state     <= ST_FETCH;
        end
        ST_FETCH: if (m_ready) begin
          case (idx)
            3'(OFS_DST):  dst_d     <= m_rdata;
            3'(OFS_NEXT): nxt_d     <= m_rdata;
            3'(OFS_CTLA): ctla      <= m_rdata[W-2:0];
            3'(OFS_CTLB): ctlb_last <= m_rdata[LAST_BIT];
            default: ;
          endcase
          if (stop_now)             state <= ST_IDLE;
          else if (idx == LAST_IDX) state <= ST_LOAD;
          else                      idx   <= idx + 3'd1;
        end
        ST_LOAD: begin
          src_cur <= src_init;
          dst_cur <= dst_d;
          cnt     <= ctla[CW-1:0];
          if (stop_now)                 state <= ST_IDLE;
          else if (ctla[CW-1:0] == '0)  state <= ST_WB;
          else                          state <= ST_RD;
        end
        ST_RD: if (m_ready) begin
          dbuf  <= m_rdata;
          state <= ST_WR;
        end
        ST_WR: if (m_ready) begin
          src_cur <= src_cur + 1'b1;
          dst_cur <= dst_cur + 1'b1;
          cnt     <= cnt - 1'b1;
          if (stop_now)             state <= ST_IDLE;
          else if (cnt == CW'(1))   state <= ST_WB;
          else                      state <= ST_RD;
        end
        ST_WB: if (m_ready) begin
          if (stop_now) state <= ST_IDLE;
          else if (last_item) begin
            evt_xfer <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            evt_buf <= 1'b1;
            ptr_cur <= nxt_d;
            idx     <= '0;
            state   <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));
  assert_wb_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_we && m_ready && state == ST_WB) |-> (cnt == '0));
  assert_evt_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_buf, evt_xfer}));
  assert_xfer_idle_R8: assert property (@(posedge clk) disable iff (rst)
    evt_xfer |-> !active);
endmodule

// File: rtl/ll_dma_channel.sv
module ll_dma_channel #(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         irq_buf,
  output logic         irq_xfer,
  output logic         m_req,
  output logic         m_we,
  output logic [W-1:0] m_addr,
  output logic [W-1:0] m_wdata,
  input  logic [W-1:0] m_rdata,
  input  logic         m_ready
);
  logic active, evt_buf, evt_xfer, glb_en, start, stop;
  logic [W-1:0] src_init, desc_ptr;

  lldma_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .active(active),
    .evt_buf(evt_buf), .evt_xfer(evt_xfer), .glb_en(glb_en), .start(start),
    .stop(stop), .src_init(src_init), .desc_ptr(desc_ptr),
    .irq_buf(irq_buf), .irq_xfer(irq_xfer)
  );

  lldma_engine #(.W(W), .CW(CW)) u_engine (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .src_init(src_init),
    .desc_ptr(desc_ptr), .active(active), .evt_buf(evt_buf), .evt_xfer(evt_xfer),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ready(m_ready)
  );

  assert_start_gated_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(glb_en));
endmodule

// File: tb/ll_dma_channel_tb.sv
`timescale 1ns/1ps
module ll_dma_channel_tb;
  localparam int W = 32;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, reg_wr, reg_rd, irq_buf, irq_xfer, m_req, m_we, m_ready;
  logic [2:0] reg_addr;
  logic [W-1:0] reg_wdata, reg_rdata, m_addr, m_wdata, m_rdata;

  ll_dma_channel u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_buf(irq_buf), .irq_xfer(irq_xfer),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ready(m_ready)
  );

  int n_checks = 0, n_fail = 0, cyc = 0, n_hs = 0, lat = 0, seed = 7;
  bit finished = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] q_addr[$], q_data[$];
  bit q_we[$];
  string q_tag[$];
  bit last_we, hold_pend;
  logic [31:0] last_addr, hold_addr;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Memory responder: 0..2 wait cycles, one-cycle ready pulse
  always @(negedge clk) begin
    if (rst) m_ready = 1'b0;
    else if (m_ready) m_ready = 1'b0;
    else if (m_req) begin
      if (lat > 0) lat--;
      else begin
        m_ready = 1'b1;
        m_rdata = mem[m_addr[9:0]];
        seed = (seed * 13 + 5) % 97;
        lat = seed % 3;
      end
    end
  end

  // Reference comparison at every accepting edge
  always @(posedge clk) begin
    if (rst) hold_pend = 1'b0;
    else begin
      if (hold_pend)
        check(m_req && m_addr == hold_addr, "R11", "request not held", m_addr, hold_addr);
      hold_pend = m_req && !m_ready;
      hold_addr = m_addr;
      if (m_req && m_ready) begin
        n_hs++;
        last_we = m_we;
        last_addr = m_addr;
        if (m_we) mem[m_addr[9:0]] = m_wdata;
        if (q_addr.size() == 0)
          check(1'b0, "R1", "unexpected access addr", m_addr, 32'h0);
        else begin
          logic [31:0] ea, ed;
          bit ew;
          string tg;
          ea = q_addr.pop_front(); ed = q_data.pop_front();
          ew = q_we.pop_front();   tg = q_tag.pop_front();
          check(m_addr == ea && m_we == ew, tg, "access address/kind", m_addr, ea);
          if (ew) check(m_wdata == ed, tg, "write data", m_wdata, ed);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      check(1'b0, "R2", "watchdog expired at cycle", cyc, 100000);
      finish_run();
    end
  end

  task automatic push(input logic [31:0] a, input bit we, input logic [31:0] d, input string tg);
    q_addr.push_back(a); q_we.push_back(we); q_data.push_back(d); q_tag.push_back(tg);
  endtask

  task automatic expect_buffer(input logic [31:0] ptr, input logic [31:0] src);
    logic [31:0] dst, ca;
    for (int k = 0; k < 5; k++) push(ptr + k, 1'b0, 32'h0, "R2");
    dst = mem[ptr[9:0] + 10'd1];
    ca  = mem[ptr[9:0] + 10'd3];
    for (int k = 0; k < int'(ca[15:0]); k++) begin
      push(src + k, 1'b0, 32'h0, "R3");          // R5: read first
      push(dst + k, 1'b1, mem[src[9:0] + k[9:0]], "R4"); // R5: then write
    end
    push(ptr + 3, 1'b1, {1'b1, ca[30:16], 16'h0}, "R6");
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (q_addr.size() == 0 && !m_req) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic set_desc(input int p, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] n, input logic [31:0] a, input logic [31:0] b);
    mem[p] = s; mem[p+1] = d; mem[p+2] = n; mem[p+3] = a; mem[p+4] = b;
  endtask

  logic [31:0] rv;

  initial begin
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    m_ready = 0; m_rdata = 0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 | (i * 7);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state
    check(!m_req, "R11", "m_req after reset", {31'b0, m_req}, 0);
    check(!irq_buf && !irq_xfer, "R9", "flags after reset", {30'b0, irq_xfer, irq_buf}, 0);
    reg_read(3'd1, rv); check(rv == 0, "R8", "active after reset", rv, 0);
    reg_read(3'd4, rv); check(rv == 0, "R9", "status after reset", rv, 0);

    // R1: start ignored with global enable clear
    reg_write(3'd1, 32'h1);
    repeat (20) @(negedge clk);
    check(n_hs == 0, "R1", "accesses with global enable off", n_hs, 0);
    reg_read(3'd1, rv); check(rv == 0, "R1", "active with global enable off", rv, 0);

    // Two-buffer chain, second ends on zero next pointer
    set_desc(32'h100, 32'h999, 32'h300, 32'h110, 32'h00AB_0003, 32'h0);
    set_desc(32'h110, 32'h777, 32'h380, 32'h0,   32'h8000_0002, 32'h0);
    reg_write(3'd0, 32'h1);
    reg_write(3'd2, 32'h200);
    reg_write(3'd3, 32'h100);
    expect_buffer(32'h100, 32'h200);
    expect_buffer(32'h110, 32'h200);
    reg_write(3'd1, 32'h1);
    for (int i = 0; i < 500 && !irq_buf && !irq_xfer; i++) @(negedge clk);
    check(irq_buf && !irq_xfer, "R7", "flags after first buffer",
          {30'b0, irq_xfer, irq_buf}, 32'h1);
    reg_read(3'd1, rv); check(rv == 1, "R8", "active mid-chain", rv, 1);
    wait_drain();
    check(q_addr.size() == 0, "R7", "chain accesses outstanding", q_addr.size(), 0);
    check(irq_xfer == 1'b1, "R8", "chain-complete flag", {31'b0, irq_xfer}, 1);
    reg_read(3'd1, rv); check(rv == 0, "R8", "active after chain", rv, 0);
    check(mem[32'h103] == 32'h80AB_0000, "R6", "written-back word 0", mem[32'h103], 32'h80AB_0000);
    check(mem[32'h113] == 32'h8000_0000, "R6", "written-back word 1", mem[32'h113], 32'h8000_0000);
    check(mem[32'h100] == 32'h999 && mem[32'h112] == 32'h0, "R6", "other descriptor words",
          mem[32'h100], 32'h999);
    check(mem[32'h381] == mem[32'h201], "R4", "copied data", mem[32'h381], mem[32'h201]);
    reg_read(3'd4, rv); check(rv == 3, "R9", "status read", rv, 3);
    reg_read(3'd4, rv); check(rv == 0, "R9", "status after clear", rv, 0);
    check(!irq_buf && !irq_xfer, "R9", "flags after clear", {30'b0, irq_xfer, irq_buf}, 0);

    // R8: last marked by control word B with a nonzero next pointer
    set_desc(32'h120, 32'h555, 32'h3C0, 32'h130, 32'h0000_0001, 32'h1);
    reg_write(3'd2, 32'h208);
    reg_write(3'd3, 32'h120);
    expect_buffer(32'h120, 32'h208);
    reg_write(3'd1, 32'h1);
    wait_drain();
    check(q_addr.size() == 0, "R8", "accesses outstanding", q_addr.size(), 0);
    reg_read(3'd4, rv); check(rv == 2, "R8", "status on end-marked descriptor", rv, 2);
    check(mem[32'h3C0] == mem[32'h208], "R3", "source reload data", mem[32'h3C0], mem[32'h208]);

    // R10: stop mid-buffer
    set_desc(32'h140, 32'h0, 32'h400, 32'h0, 32'h0000_0014, 32'h0);
    reg_write(3'd2, 32'h200);
    reg_write(3'd3, 32'h140);
    expect_buffer(32'h140, 32'h200);
    reg_write(3'd1, 32'h1);
    begin
      int base;
      base = n_hs;
      for (int i = 0; i < 500 && n_hs < base + 12; i++) @(negedge clk);
    end
    reg_write(3'd1, 32'h0);
    repeat (40) @(negedge clk);
    check(!m_req, "R10", "request after stop", {31'b0, m_req}, 0);
    reg_read(3'd1, rv); check(rv == 0, "R10", "active after stop", rv, 0);
    check(last_we && last_addr >= 32'h400 && last_addr < 32'h414, "R10",
          "final access is a data write", last_addr, 32'h400);
    check(mem[32'h143] == 32'h14, "R10", "no write-back", mem[32'h143], 32'h14);
    check(q_addr.size() != 0, "R10", "beats left unissued", q_addr.size(), 1);
    reg_read(3'd4, rv); check(rv == 0, "R10", "no flags after stop", rv, 0);
    q_addr.delete(); q_data.delete(); q_we.delete(); q_tag.delete();

    finish_run();
  end
endmodule